// File: doc/BRIEF.md
# Multiline Serial Parameter and Data Loader

This block receives configuration and character traffic for a bank of serial lines from a host output port. Each command is a pair of 16-bit words: a channel word, whose bits 14:10 select one of 32 channel numbers, and a command word. The command word either sets up a line or carries a character. Setup words go to one of two parameter files. The transmit file covers the 16 user lines. The receive file covers those 16 lines plus 5 receive-only diagnostic channels. Character words fill a line's transmit buffer and start that line's busy timer.

Each user line has a countdown that stands in for the time the character takes to leave the line. When it runs out, the line raises a one-cycle done pulse. Loading a character while the countdown is still running marks the line as having lost a character. Serialisation, bit timing and interrupt ordering belong to neighbouring blocks. Those blocks read the stored state through a combinational readback port and watch the per-line done pulses.

The command interface is valid/ready. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is always high, because every command is absorbed in one cycle. There is therefore no back-pressure, and the host may present a new command every cycle.

Top module: `mux_line_loader`

## Requirements
- R1: A synchronous reset clears every transmit and receive parameter, every transmit buffer, every busy countdown, every lost flag and every done pulse; readback of any channel then returns zero.
- R2: A command word with bit 15 = 1 and bit 14 = 1 is a transmit setup word. It is stored whole in the transmit parameter file when the channel is below 16, and is dropped without effect for channels 16 to 31.
- R3: A command word with bit 15 = 1 and bit 14 = 0 is a receive setup word. It is stored whole in the receive parameter file when the channel is below 21, and is dropped without effect for channels 21 to 31.
- R4: A command word with bit 15 = 0 and bit 14 = 1, aimed at a channel below 16, loads bits 9:0 into that line's transmit buffer. If the line is idle, it also makes the line busy from the next cycle.
- R5: A line that is started stays busy for exactly WAIT_TICKS cycles. Its `tx_done` bit is high for exactly one cycle, the first cycle in which busy is low again, and is low at all other times.
- R6: A character loaded into a busy line sets that line's lost flag (readback status value 2, bit 1) and still replaces the buffer. The countdown is not restarted. The lost flag stays set until reset.
- R7: A command word with bit 15 = 0 and bit 14 = 0, or a character word aimed at channel 16 or above, changes no buffer, countdown, lost flag or parameter.
- R8: Only bits 14:10 of the channel word select the channel; its other bits have no effect.
- R9: Within a setup word, bit 13 is the line enable, bit 12 is transmit parity or receive echo, bit 11 is transmit sync or receive diagnose, bits 10:8 are the character length and bits 7:0 are the rate code. All of them read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid (always high) |
| cmd_hi | input | 16 | Channel word, channel in bits 14:10 |
| cmd_lo | input | 16 | Command word: setup or character |
| rd_chan | input | 5 | Channel to read back |
| rd_xpar | output | 16 | Transmit parameter of rd_chan, zero above 15 |
| rd_rpar | output | 16 | Receive parameter of rd_chan, zero above 20 |
| rd_xbuf | output | 10 | Transmit buffer of rd_chan, zero above 15 |
| rd_status | output | 2 | Bit 1 lost flag, bit 0 busy, of rd_chan; zero above 15 |
| tx_done | output | 16 | One-cycle done pulse per user line |

## Verification
A wrong internal state in this block appears on the readback port in the very next cycle. This covers a parameter written into the wrong file, a buffer loaded from an ignored command, and a lost flag set on an idle line. A countdown that starts late or runs off by one shows as a `tx_done` pulse that arrives one or more cycles away from WAIT_TICKS, or as a busy bit that disagrees at readback. A countdown that is wrongly restarted by a second load delays the pulse by up to WAIT_TICKS cycles. The bench checks `tx_done` on every cycle, so any such shift is seen when the pulse is due.

// File: rtl/mux_ldr_pkg.sv
package mux_ldr_pkg;

  // Layout of a setup word; the two header bits steer the command.
  typedef struct packed {
    logic       is_setup;   // bit 15
    logic       is_tx;      // bit 14
    logic       enable;     // bit 13
    logic       opt_a;      // bit 12: parity (tx) / echo (rx)
    logic       opt_b;      // bit 11: sync (tx) / diagnose (rx)
    logic [2:0] char_len;   // bits 10:8
    logic [7:0] rate;       // bits 7:0
  } setup_word_t;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_XPAR = 2'd1,
    CMD_RPAR = 2'd2,
    CMD_DATA = 2'd3
  } cmd_kind_t;

  localparam int CHAN_LSB = 10;

endpackage

// File: rtl/mux_ldr_decode.sv
module mux_ldr_decode
  import mux_ldr_pkg::*;
#(
  parameter int NUM_USER = 16,
  parameter int NUM_RX   = 21,
  parameter int CH_W     = 5
) (
  input  logic            valid,
  input  logic [15:0]     hi_word,
  input  logic [15:0]     lo_word,
  output cmd_kind_t       kind,
  output logic [CH_W-1:0] chan
);
  setup_word_t hdr;

  always_comb begin
    hdr  = setup_word_t'(lo_word);
    chan = hi_word[CHAN_LSB +: CH_W];
    kind = CMD_NONE;
    if (valid) begin
      if (hdr.is_setup) begin
        if (hdr.is_tx && (chan < CH_W'(NUM_USER)))       kind = CMD_XPAR;
        else if (!hdr.is_tx && (chan < CH_W'(NUM_RX)))   kind = CMD_RPAR;
      end else if (hdr.is_tx && (chan < CH_W'(NUM_USER))) begin
        kind = CMD_DATA;
      end
    end
  end
endmodule

// File: rtl/mux_ldr_param_file.sv
module mux_ldr_param_file #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CH_W-1:0]   wchan,
  input  logic [WORD_W-1:0] wdata,
  input  logic [CH_W-1:0]   rchan,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && (wchan < CH_W'(DEPTH))) begin
      mem[wchan] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rchan < CH_W'(DEPTH)) rdata = mem[rchan];
  end
endmodule

// File: rtl/mux_ldr_tx_line.sv
module mux_ldr_tx_line #(
  parameter int CHAR_W     = 10,
  parameter int WAIT_TICKS = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CHAR_W-1:0] load_char,
  output logic [CHAR_W-1:0] xbuf,
  output logic              busy,
  output logic              lost,
  output logic              done
);
  localparam int CNT_W = $clog2(WAIT_TICKS + 1);

  logic [CNT_W-1:0] remain;

  assign busy = (remain != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      xbuf   <= '0;
      lost   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= busy && (remain == CNT_W'(1));
      if (load) xbuf <= load_char;
      if (load && busy) lost <= 1'b1;
      if (load && !busy)  remain <= CNT_W'(WAIT_TICKS);
      else if (busy)      remain <= remain - CNT_W'(1);
    end
  end
endmodule

// File: rtl/mux_line_loader.sv
module mux_line_loader
  import mux_ldr_pkg::*;
#(
  parameter int NUM_USER   = 16,
  parameter int NUM_DIAG   = 5,
  parameter int CHAR_W     = 10,
  parameter int WAIT_TICKS = 500
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [15:0]         cmd_hi,
  input  logic [15:0]         cmd_lo,
  input  logic [4:0]          rd_chan,
  output logic [15:0]         rd_xpar,
  output logic [15:0]         rd_rpar,
  output logic [CHAR_W-1:0]   rd_xbuf,
  output logic [1:0]          rd_status,
  output logic [NUM_USER-1:0] tx_done
);
  localparam int NUM_RX = NUM_USER + NUM_DIAG;
  localparam int CH_W   = 5;
  localparam int LIDX_W = $clog2(NUM_USER);

  cmd_kind_t       kind;
  logic [CH_W-1:0] chan;

  logic [NUM_USER-1:0] load_vec;
  logic [NUM_USER-1:0] busy_vec;
  logic [NUM_USER-1:0] lost_vec;
  logic [CHAR_W-1:0]   xbuf_arr [NUM_USER];

  assign cmd_ready = 1'b1;

  mux_ldr_decode #(
    .NUM_USER(NUM_USER), .NUM_RX(NUM_RX), .CH_W(CH_W)
  ) dec_i (
    .valid(cmd_valid && cmd_ready), .hi_word(cmd_hi), .lo_word(cmd_lo),
    .kind(kind), .chan(chan)
  );

  mux_ldr_param_file #(.DEPTH(NUM_USER), .WORD_W(16), .CH_W(CH_W)) xpar_i (
    .clk(clk), .rst(rst), .we(kind == CMD_XPAR), .wchan(chan),
    .wdata(cmd_lo), .rchan(rd_chan), .rdata(rd_xpar)
  );

  mux_ldr_param_file #(.DEPTH(NUM_RX), .WORD_W(16), .CH_W(CH_W)) rpar_i (
    .clk(clk), .rst(rst), .we(kind == CMD_RPAR), .wchan(chan),
    .wdata(cmd_lo), .rchan(rd_chan), .rdata(rd_rpar)
  );

  for (genvar g = 0; g < NUM_USER; g++) begin : g_line
    assign load_vec[g] = (kind == CMD_DATA) && (chan == CH_W'(g));
    mux_ldr_tx_line #(.CHAR_W(CHAR_W), .WAIT_TICKS(WAIT_TICKS)) line_i (
      .clk(clk), .rst(rst), .load(load_vec[g]),
      .load_char(cmd_lo[CHAR_W-1:0]), .xbuf(xbuf_arr[g]),
      .busy(busy_vec[g]), .lost(lost_vec[g]), .done(tx_done[g])
    );
  end

  always_comb begin
    rd_xbuf   = '0;
    rd_status = '0;
    if (rd_chan < CH_W'(NUM_USER)) begin
      rd_xbuf   = xbuf_arr[rd_chan[LIDX_W-1:0]];
      rd_status = {lost_vec[rd_chan[LIDX_W-1:0]], busy_vec[rd_chan[LIDX_W-1:0]]};
    end
  end
endmodule

// File: rtl/mux_line_loader_chk.sv
module mux_line_loader_chk #(
  parameter int NUM_USER = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                cmd_valid,
  input logic [15:0]         cmd_hi,
  input logic [15:0]         cmd_lo,
  input logic [NUM_USER-1:0] busy_vec,
  input logic [NUM_USER-1:0] lost_vec,
  input logic [NUM_USER-1:0] tx_done
);
  logic char_cmd, idle_cmd, high_cmd;
  assign char_cmd = cmd_valid && !cmd_lo[15] && cmd_lo[14];
  assign idle_cmd = cmd_valid && !cmd_lo[15] && !cmd_lo[14];
  assign high_cmd = char_cmd && (cmd_hi[14:10] >= 5'(NUM_USER));

  // R1: reset leaves no line busy and no done pulse
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (busy_vec == '0 && tx_done == '0));

  // R7: ignored commands leave the lost flags alone
  p_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (idle_cmd || high_cmd) |=> $stable(lost_vec));

  for (genvar g = 0; g < NUM_USER; g++) begin : g_prop
    logic hit;
    assign hit = char_cmd && (cmd_hi[14:10] == 5'(g));

    // R4: a character on an idle line makes it busy
    p_start_r4: assert property (@(posedge clk) disable iff (rst)
      (hit && !busy_vec[g]) |=> busy_vec[g]);

    // R6: a character on a busy line sets lost
    p_lost_r6: assert property (@(posedge clk) disable iff (rst)
      (hit && busy_vec[g]) |=> lost_vec[g]);

    // R5: done follows the end of a busy period
    p_done_edge_r5: assert property (@(posedge clk) disable iff (rst)
      tx_done[g] |-> (!busy_vec[g] && $past(busy_vec[g])));

    // R5: done lasts one cycle
    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
      tx_done[g] |=> !tx_done[g]);
  end
endmodule

bind mux_line_loader mux_line_loader_chk #(.NUM_USER(NUM_USER)) chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_hi(cmd_hi),
  .cmd_lo(cmd_lo), .busy_vec(busy_vec), .lost_vec(lost_vec),
  .tx_done(tx_done)
);

// File: tb/mux_line_loader_tb_top.sv
module mux_line_loader_tb_top;
  localparam int NU = 16;
  localparam int NR = 21;
  localparam int WT = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_hi = '0, cmd_lo = '0;
  logic [4:0]  rd_chan = '0;
  logic [15:0] rd_xpar, rd_rpar;
  logic [9:0]  rd_xbuf;
  logic [1:0]  rd_status;
  logic [NU-1:0] tx_done;

  mux_line_loader #(.WAIT_TICKS(WT)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .rd_chan(rd_chan),
    .rd_xpar(rd_xpar), .rd_rpar(rd_rpar), .rd_xbuf(rd_xbuf),
    .rd_status(rd_status), .tx_done(tx_done)
  );

  int checks = 0;
  int errors = 0;

  logic [15:0]   m_xpar [NU];
  logic [15:0]   m_rpar [NR];
  logic [9:0]    m_xbuf [NU];
  logic          m_lost [NU];
  int            m_rem  [NU];
  logic [NU-1:0] m_done;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NU; i++) begin
      m_xpar[i] = '0; m_xbuf[i] = '0; m_lost[i] = 1'b0; m_rem[i] = 0;
    end
    for (int i = 0; i < NR; i++) m_rpar[i] = '0;
    m_done = '0;
  endtask

  task automatic model_update(logic v, logic [15:0] hi, logic [15:0] lo);
    int ch;
    ch = int'(hi[14:10]);
    if (rst) begin
      model_clear();
      return;
    end
    for (int i = 0; i < NU; i++) begin
      bit busy_b, ld;
      busy_b    = (m_rem[i] != 0);
      m_done[i] = (m_rem[i] == 1);
      ld = v && !lo[15] && lo[14] && (ch == i);
      if (ld) begin
        m_xbuf[i] = lo[9:0];
        if (busy_b) m_lost[i] = 1'b1;
      end
      if (ld && !busy_b)   m_rem[i] = WT;
      else if (busy_b)     m_rem[i] = m_rem[i] - 1;
    end
    if (v && lo[15]) begin
      if (lo[14] && ch < NU)       m_xpar[ch] = lo;
      else if (!lo[14] && ch < NR) m_rpar[ch] = lo;
    end
  endtask

  // one clock: drive at negedge, model at posedge, check done (R5)
  task automatic step(logic v, logic [15:0] hi, logic [15:0] lo);
    @(negedge clk);
    cmd_valid = v; cmd_hi = hi; cmd_lo = lo;
    @(posedge clk);
    model_update(v, hi, lo);
    #1;
    cmd_valid = 1'b0;
    chk("R5 tx_done", 32'(tx_done), 32'(m_done));
  endtask

  task automatic readback(logic [4:0] ch, string req);
    int c;
    c = int'(ch);
    rd_chan = ch;
    #1;
    chk({req, " xpar"}, 32'(rd_xpar), (c < NU) ? 32'(m_xpar[c]) : 32'd0);
    chk({req, " rpar"}, 32'(rd_rpar), (c < NR) ? 32'(m_rpar[c]) : 32'd0);
    chk({req, " xbuf"}, 32'(rd_xbuf), (c < NU) ? 32'(m_xbuf[c]) : 32'd0);
    chk({req, " status"}, 32'(rd_status),
        (c < NU) ? 32'({m_lost[c], 1'(m_rem[c] != 0)}) : 32'd0);
  endtask

  function automatic logic [15:0] hi_of(logic [4:0] ch, logic junk);
    return {junk, ch, {10{junk}}};
  endfunction

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    model_clear();
    rst = 1'b1;
    step(1'b1, hi_of(5'd3, 1'b0), 16'hC0AA);
    step(1'b0, '0, '0);
    rst = 1'b0;
    readback(5'd0, "R1");
    readback(5'd20, "R1");
    chk("R1 ready", 32'(cmd_ready), 32'd1);

    // R8 and R9: junk in channel word, all setup fields survive
    step(1'b1, hi_of(5'd3, 1'b1), 16'hFDA7);
    readback(5'd3, "R9");
    step(1'b1, hi_of(5'd15, 1'b0), 16'hC2FF);
    readback(5'd15, "R2");
    step(1'b1, hi_of(5'd16, 1'b1), 16'hC0FF);
    readback(5'd16, "R2");

    step(1'b1, hi_of(5'd20, 1'b1), 16'hB123);
    readback(5'd20, "R3");
    step(1'b1, hi_of(5'd21, 1'b0), 16'hA0F0);
    readback(5'd21, "R3");
    step(1'b1, hi_of(5'd5, 1'b0), 16'h9E01);
    readback(5'd5, "R8");

    // R4 then R6: second load on a busy line
    step(1'b1, hi_of(5'd7, 1'b1), 16'h4155);
    readback(5'd7, "R4");
    step(1'b1, hi_of(5'd7, 1'b0), 16'h4266);
    readback(5'd7, "R6");
    for (int k = 0; k < WT + 2; k++) step(1'b0, '0, '0);
    readback(5'd7, "R5");

    // R7: char word with bit 14 clear, and char to channel 17
    step(1'b1, hi_of(5'd2, 1'b0), 16'h0123);
    readback(5'd2, "R7");
    step(1'b1, hi_of(5'd17, 1'b0), 16'h4321);
    readback(5'd17, "R7");
    readback(5'd1, "R7");

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [4:0]  ch;
      logic [15:0] lo;
      logic        v;
      ch = 5'($urandom_range(0, 31));
      if (($urandom % 4) != 0) ch = 5'($urandom_range(0, 3));
      lo = 16'($urandom);
      v  = ($urandom % 3) != 0;
      step(v, {1'($urandom), ch, 10'($urandom)}, lo);
      readback(5'($urandom_range(0, 31)), "R2 R3 R4 R6 R7 R8");
    end

    // R1: reset with state present
    rst = 1'b1;
    step(1'b1, hi_of(5'd0, 1'b0), 16'h4001);
    rst = 1'b0;
    for (int c = 0; c < 24; c++) readback(5'(c), "R1");

    finish_run();
  end
endmodule